// File: doc/BRIEF.md
# Split-Word Masked GPIO Register Bank

This block is the register front end of a 32-pin general-purpose I/O bank. Software reaches it over a simple memory-mapped bus with address, write strobe, write data, read strobe and read data. The block drives an output-value bus and an output-enable bus toward the pads. Each 32-bit logical register is stored as two 16-bit halves, and each half has a word address of its own. When a half is written, the upper 16 bits of the bus word select which of the lower 16 bits take the new value. Firmware can therefore change one pin, or any group of pins, in a single write with no read-modify-write sequence and no lock.

Two configuration registers live in this form: the output-value register and the direction register. A read-only port-level word returns the pad inputs after a two-flop synchronizer. A read-only identification word returns a fixed version constant. Interrupt and debounce functions sit outside this block.

Top module: `pinbank_regs`

## Requirements
- R1: After reset, every output-value bit and every direction bit is 0, so padOut and padOe are both all zero and every pin is an input.
- R2: The output-value register holds pins 15:0 at byte offset 0x00 and pins 31:16 at offset 0x04. padOut shows the whole register, whatever the direction bits are.
- R3: When a half is written, bit n of that half (n in 0..15) takes busWdata[n] only if busWdata[n+16] is 1. Bits whose enable is 0 keep their old value, and the other half does not change.
- R4: A read of any register half returns its 16 stored bits in busRdata[15:0], with busRdata[31:16] equal to 0.
- R5: The direction register holds pins 15:0 at offset 0x08 and pins 31:16 at offset 0x0C. It is written with the same masking. padOe equals the register, and a 1 makes the pin an output.
- R6: A read of offset 0x70 returns all 32 pad levels in one plain word, bit i for pin i, after a two-flop synchronizer. A read issued one cycle after a pad change returns the old level. A read issued two cycles after it returns the new level.
- R7: A read of offset 0x78 returns 0x01000C2B.
- R8: A read of any other offset returns 0. A write to 0x70, to 0x78 or to any unmapped offset leaves padOut, padOe and the identification value unchanged.
- R9: Read data is registered. busRdata takes the addressed value at the clock edge that samples busRd, and it holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 8 | Byte address; bits 1:0 are ignored |
| busWr | input | 1 | Write strobe, one cycle per write |
| busWdata | input | 32 | Write word: [31:16] enables, [15:0] values |
| busRd | input | 1 | Read strobe |
| busRdata | output | 32 | Registered read data |
| padIn | input | 32 | Asynchronous pad input levels |
| padOut | output | 32 | Output value toward the pads |
| padOe | output | 32 | Output enable toward the pads, 1 = drive |

## Verification
The sweep walks a single set and a single clear through every bit of both halves of both writable registers. A design that swapped the halves, or that shifted the enable field by the wrong amount, would move the wrong pin. Pseudo-random masked writes are checked against a model of the register. A design that ignored the enables, or that cleared the unselected bits, would lose values there. The port-level word is read exactly one and exactly two cycles after a pad change, which exposes a synchronizer with the wrong depth. Writes to the read-only and unmapped offsets, followed by reads of them, show any decode that aliases an address onto a live register.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;
  typedef enum logic [2:0] {
    RD_NONE, RD_VAL_LO, RD_VAL_HI, RD_DIR_LO, RD_DIR_HI, RD_LEVEL, RD_IDENT
  } rdSel_e;

  typedef struct packed {
    logic [1:0] valWr;   // one per half: 0 = pins low, 1 = pins high
    logic [1:0] dirWr;
    logic       rdEn;
    rdSel_e     rdSel;
  } strobe_t;
endpackage

// File: rtl/pinbank_decode.sv
module pinbank_decode
  import pinbank_pkg::*;
#(
  parameter int          ADDR_W  = 8,
  parameter logic [7:0]  VAL_OFS = 8'h00,
  parameter logic [7:0]  DIR_OFS = 8'h08,
  parameter logic [7:0]  LVL_OFS = 8'h70,
  parameter logic [7:0]  ID_OFS  = 8'h78
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  output strobe_t           strobe
);
  localparam int WI_W = ADDR_W - 2;

  logic [WI_W-1:0] wordIdx;
  logic [1:0]      hitVal, hitDir;
  logic            hitLvl, hitId;

  assign wordIdx = busAddr[ADDR_W-1:2];

  for (genvar h = 0; h < 2; h++) begin : g_hit
    localparam logic [7:0] V_ADDR = VAL_OFS + 8'(4 * h);
    localparam logic [7:0] D_ADDR = DIR_OFS + 8'(4 * h);
    assign hitVal[h] = (wordIdx == V_ADDR[ADDR_W-1:2]);
    assign hitDir[h] = (wordIdx == D_ADDR[ADDR_W-1:2]);
  end

  assign hitLvl = (wordIdx == LVL_OFS[ADDR_W-1:2]);
  assign hitId  = (wordIdx == ID_OFS[ADDR_W-1:2]);

  always_comb begin
    strobe.valWr = hitVal & {2{busWr}};
    strobe.dirWr = hitDir & {2{busWr}};
    strobe.rdEn  = busRd;
    if      (hitVal[0]) strobe.rdSel = RD_VAL_LO;
    else if (hitVal[1]) strobe.rdSel = RD_VAL_HI;
    else if (hitDir[0]) strobe.rdSel = RD_DIR_LO;
    else if (hitDir[1]) strobe.rdSel = RD_DIR_HI;
    else if (hitLvl)    strobe.rdSel = RD_LEVEL;
    else if (hitId)     strobe.rdSel = RD_IDENT;
    else                strobe.rdSel = RD_NONE;
  end
endmodule

// File: rtl/pinbank_store.sv
module pinbank_store
  import pinbank_pkg::*;
#(
  parameter int          HALF_W  = 16,
  parameter int          SYNC_N  = 2,
  parameter logic [31:0] IDENT   = 32'h0100_0C2B,
  localparam int         WORD_W  = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [WORD_W-1:0] busWdata,
  input  logic [WORD_W-1:0] padIn,
  output logic [WORD_W-1:0] busRdata,
  output logic [WORD_W-1:0] padOut,
  output logic [WORD_W-1:0] padOe
);
  logic [HALF_W-1:0] valHalf [2];
  logic [HALF_W-1:0] dirHalf [2];
  logic [HALF_W-1:0] wEn, wVal;
  logic [WORD_W-1:0] syncQ [SYNC_N];
  logic [WORD_W-1:0] rdNext;

  assign wEn  = busWdata[WORD_W-1:HALF_W];
  assign wVal = busWdata[HALF_W-1:0];

  for (genvar h = 0; h < 2; h++) begin : g_half
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        valHalf[h] <= '0;
        dirHalf[h] <= '0;
      end else begin
        if (strobe.valWr[h]) valHalf[h] <= (valHalf[h] & ~wEn) | (wVal & wEn);
        if (strobe.dirWr[h]) dirHalf[h] <= (dirHalf[h] & ~wEn) | (wVal & wEn);
      end
    end
  end

  assign padOut = {valHalf[1], valHalf[0]};
  assign padOe  = {dirHalf[1], dirHalf[0]};

  for (genvar s = 0; s < SYNC_N; s++) begin : g_sync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)       syncQ[s] <= '0;
      else if (s == 0) syncQ[s] <= padIn;
      else             syncQ[s] <= syncQ[(s > 0) ? s - 1 : 0];
    end
  end

  always_comb begin
    unique case (strobe.rdSel)
      RD_VAL_LO: rdNext = {{HALF_W{1'b0}}, valHalf[0]};
      RD_VAL_HI: rdNext = {{HALF_W{1'b0}}, valHalf[1]};
      RD_DIR_LO: rdNext = {{HALF_W{1'b0}}, dirHalf[0]};
      RD_DIR_HI: rdNext = {{HALF_W{1'b0}}, dirHalf[1]};
      RD_LEVEL:  rdNext = syncQ[SYNC_N-1];
      RD_IDENT:  rdNext = WORD_W'(IDENT);
      default:   rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            busRdata <= '0;
    else if (strobe.rdEn) busRdata <= rdNext;
  end
endmodule

// File: rtl/pinbank_regs.sv
module pinbank_regs
  import pinbank_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [7:0]  busAddr,
  input  logic        busWr,
  input  logic [31:0] busWdata,
  input  logic        busRd,
  output logic [31:0] busRdata,
  input  logic [31:0] padIn,
  output logic [31:0] padOut,
  output logic [31:0] padOe
);
  strobe_t strobe;

  pinbank_decode #(.ADDR_W(8)) u_decode (
    .busAddr(busAddr), .busWr(busWr), .busRd(busRd), .strobe(strobe)
  );

  pinbank_store #(.HALF_W(16), .SYNC_N(2)) u_store (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busWdata(busWdata),
    .padIn(padIn), .busRdata(busRdata), .padOut(padOut), .padOe(padOe)
  );
endmodule

// File: rtl/pinbank_regs_chk.sv
module pinbank_regs_chk (
  input logic        clk,
  input logic        rstN,
  input logic [7:0]  busAddr,
  input logic        busWr,
  input logic [31:0] busWdata,
  input logic        busRd,
  input logic [31:0] busRdata,
  input logic [31:0] padIn,
  input logic [31:0] padOut,
  input logic [31:0] padOe
);
  logic loVal, hiVal;
  assign loVal = busWr && (busAddr[7:2] == 6'h00);
  assign hiVal = busWr && (busAddr[7:2] == 6'h01);

  // R3
  masked_bits_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    loVal |=> (((padOut[15:0] ^ $past(padOut[15:0])) & ~$past(busWdata[31:16])) == 16'h0));

  // R3
  other_half_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    hiVal |=> (padOut[15:0] == $past(padOut[15:0])));

  // R8
  no_write_no_change_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busWr |=> ($stable(padOut) && $stable(padOe)));

  // R7
  ident_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && busAddr[7:2] == 6'h1E) |=> (busRdata == 32'h0100_0C2B));

  // R8
  unmapped_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && busAddr[7:2] == 6'h10) |=> (busRdata == 32'h0));

  // R9
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busRd |=> $stable(busRdata));

  // R4
  half_upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && busAddr[7:4] == 4'h0) |=> (busRdata[31:16] == 16'h0));
endmodule

bind pinbank_regs pinbank_regs_chk u_chk (.*);

// File: tb/pinbank_regs_bench.sv
module pinbank_regs_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWr = 1'b0;
  logic [31:0] busWdata = '0;
  logic        busRd = 1'b0;
  logic [31:0] busRdata;
  logic [31:0] padIn = '0;
  logic [31:0] padOut, padOe;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  logic [31:0] expVal = '0, expDir = '0;
  logic [31:0] seed = 32'h1234_5678;

  always #2.5 clk = ~clk;

  pinbank_regs u_pinbank_regs (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busWdata(busWdata),
    .busRd(busRd), .busRdata(busRdata), .padIn(padIn), .padOut(padOut), .padOe(padOe)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] q);
    busAddr = a; busRd = 1'b1;
    @(negedge clk);
    busRd = 1'b0;
    q = busRdata;
  endtask

  function automatic logic [31:0] apply(input logic [31:0] old, input bit hi, input logic [31:0] d);
    logic [31:0] en, v;
    en = {16'h0, d[31:16]};
    v  = {16'h0, d[15:0]};
    if (hi) begin en = en << 16; v = v << 16; end
    return (old & ~en) | (v & en);
  endfunction

  function automatic logic [31:0] nextRand(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    return y ^ (y << 5);
  endfunction

  initial begin
    logic [31:0] q;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 padOut", padOut, 32'h0);
    chk("R1 padOe", padOe, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    rd(8'h00, q); chk("R1 val lo", q, 32'h0);
    rd(8'h0C, q); chk("R1 dir hi", q, 32'h0);

    // R2 R5 R3 R4 walk one set and one clear through every bit
    for (int r = 0; r < 2; r++) begin
      for (int h = 0; h < 2; h++) begin
        for (int b = 0; b < 16; b++) begin
          logic [7:0] a;
          logic [31:0] d;
          a = 8'(r * 8 + h * 4);
          d = (32'h1 << (b + 16)) | (32'h1 << b);
          wr(a, d);
          if (r == 0) begin expVal = apply(expVal, h[0], d); chk("R2 set", padOut, expVal); end
          else begin expDir = apply(expDir, h[0], d); chk("R5 set", padOe, expDir); end
          rd(a, q);
          chk("R4 readback", q, {16'h0, (r == 0 ? expVal : expDir) >> (16 * h)} & 32'h0000_FFFF);
          d = 32'h1 << (b + 16);
          wr(a, d);
          if (r == 0) begin expVal = apply(expVal, h[0], d); chk("R3 clr", padOut, expVal); end
          else begin expDir = apply(expDir, h[0], d); chk("R3 clr dir", padOe, expDir); end
        end
      end
    end

    // R3 pseudo-random masked writes to both registers and halves
    for (int i = 0; i < 64; i++) begin
      logic [7:0] a;
      seed = nextRand(seed);
      a = {4'h0, seed[4], seed[3], 2'b00};
      wr(a, seed);
      if (a[3]) expDir = apply(expDir, a[2], seed);
      else      expVal = apply(expVal, a[2], seed);
      chk("R3 masked val", padOut, expVal);
      chk("R5 masked dir", padOe, expDir);
    end
    rd(8'h04, q); chk("R4 val hi", q, {16'h0, expVal[31:16]});
    rd(8'h08, q); chk("R4 dir lo", q, {16'h0, expDir[15:0]});

    // R6 synchronizer depth
    padIn = 32'hA5C3_0F96;
    @(negedge clk);
    rd(8'h70, q); chk("R6 one cycle old", q, 32'h0);
    rd(8'h70, q); chk("R6 two cycles new", q, 32'hA5C3_0F96);
    padIn = 32'h5A3C_F069;
    @(negedge clk); @(negedge clk);
    rd(8'h70, q); chk("R6 level", q, 32'h5A3C_F069);

    // R7 identification
    rd(8'h78, q); chk("R7 ident", q, 32'h0100_0C2B);

    // R8 writes to read-only and unmapped offsets do nothing
    wr(8'h70, 32'hFFFF_FFFF);
    wr(8'h74, 32'hFFFF_FFFF);
    wr(8'h78, 32'hFFFF_FFFF);
    wr(8'h20, 32'hFFFF_FFFF);
    wr(8'h10, 32'hFFFF_FFFF);
    chk("R8 padOut kept", padOut, expVal);
    chk("R8 padOe kept", padOe, expDir);
    rd(8'h78, q); chk("R8 ident kept", q, 32'h0100_0C2B);
    rd(8'h70, q); chk("R8 level kept", q, 32'h5A3C_F069);
    rd(8'h20, q); chk("R8 unmapped 20", q, 32'h0);
    rd(8'h40, q); chk("R8 unmapped 40", q, 32'h0);
    rd(8'h7C, q); chk("R8 unmapped 7C", q, 32'h0);

    // R9 read data holds with no read
    rd(8'h78, q);
    wr(8'h00, 32'hFFFF_1234);
    expVal = apply(expVal, 1'b0, 32'hFFFF_1234);
    padIn = 32'h0;
    repeat (3) @(negedge clk);
    chk("R9 hold", busRdata, 32'h0100_0C2B);
    rd(8'h00, q); chk("R9 new read", q, {16'h0, expVal[15:0]});
    chk("R2 value", padOut, expVal);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule